// File: doc/BRIEF.md
# Exclusive Reservation Monitor

This block sits in front of a shared memory and keeps one exclusive-access reservation per requesting context. A load-reserved request records the requester's address, rounded down to a reservation granule. Each store is checked against the table. A plain store always goes ahead. A store-conditional goes ahead only when the requester still holds a reservation on the same granule.

A store that goes ahead removes every reservation on its granule, whatever context owns it. Each owner other than the requester is then sent a clear-exclusive notice. These notices come out one per cycle, lowest context number first, and a busy flag stays high until the last one has been sent. A store-conditional that fails leaves the table exactly as it was.

The decision outputs are combinational on the request and are valid in the same cycle as the request strobe. The table update happens on the clock edge that closes that cycle.

Top module: `resv_monitor`

## Requirements
- R1: After synchronous reset no context holds a reservation, `busy` and `clr_valid` are 0, and a store-conditional issued next fails.
- R2: A load-reserved (cmd code 1) records the address with its low log2(GRAN_BYTES) bits dropped. A later store-conditional (cmd code 3) from the same context to any address in that granule succeeds, with `store_ok`=1 and `sc_status`=1 in the request cycle.
- R3: A second load-reserved from a context replaces its earlier reservation. A store-conditional to the old granule then fails.
- R4: A store-conditional fails (`store_ok`=0, `sc_status`=0) when the requester has no reservation, when its reservation is on a different granule, or when only another context holds the granule.
- R5: A plain store (cmd code 2) always gives `store_ok`=1 and `sc_status`=0.
- R6: A store that goes ahead (a plain store or a successful conditional) removes every context's reservation on its granule, including the requester's own, and leaves reservations on other granules in place.
- R7: A failed store-conditional removes no reservation at all.
- R8: For each reservation removed by R6 whose owner is not the requester, a clear-exclusive notice carrying that owner's number is sent, the first one in the cycle after the store. The requester is never notified.
- R9: Several notices from one store come out one per cycle in ascending context order. `busy` is 1 in every cycle that a notice is pending and 0 once the last has been sent.
- R10: A plain load (cmd code 0) changes no reservation and gives `store_ok`=0 and `sc_status`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_cmd | input | 2 | 0 load, 1 load-reserved, 2 store, 3 store-conditional |
| req_addr | input | ADDR_W | Byte address |
| req_ctx | input | CTX_W | Requesting context number |
| store_ok | output | 1 | Store may proceed (same cycle) |
| sc_status | output | 1 | Store-conditional result, 1 success (same cycle) |
| clr_valid | output | 1 | Clear-exclusive notice strobe |
| clr_ctx | output | CTX_W | Context whose reservation was cleared |
| busy | output | 1 | Notices still pending |

## Verification
The hardest case to reach is one store that removes several foreign reservations at once. Reaching it requires several contexts to hold reservations on the same granule, while a further context holds an unrelated granule that must survive the store. The bench builds this state with a chain of load-reserved requests. It then issues a plain store from one of the owners and follows the notice train cycle by cycle to check the order, that the requester is left out, and when `busy` drops. Afterwards it probes each context with store-conditionals, because a reservation can only be seen through the ports this way.

// File: rtl/resv_pkg.sv
package resv_pkg;

    typedef enum logic [1:0] {
        CMD_LOAD       = 2'd0,
        CMD_LOAD_RSV   = 2'd1,
        CMD_STORE      = 2'd2,
        CMD_STORE_COND = 2'd3
    } resv_cmd_e;

    typedef struct packed {
        logic reserve;
        logic plain_st;
        logic cond_st;
    } cmd_class_t;

    function automatic cmd_class_t classify(input logic vld, input resv_cmd_e c);
        cmd_class_t r;
        r.reserve  = vld && (c == CMD_LOAD_RSV);
        r.plain_st = vld && (c == CMD_STORE);
        r.cond_st  = vld && (c == CMD_STORE_COND);
        return r;
    endfunction

endpackage

// File: rtl/resv_table.sv
module resv_table #(
    parameter int NUM_CTX = 4,
    parameter int TAG_W   = 28,
    parameter int CTX_W   = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               set_en,
    input  logic [CTX_W-1:0]   set_idx,
    input  logic [TAG_W-1:0]   probe_tag,
    input  logic [NUM_CTX-1:0] kill_mask,
    output logic [NUM_CTX-1:0] tag_hit,
    output logic [NUM_CTX-1:0] valid_vec
);

    logic [TAG_W-1:0] tag_q [NUM_CTX];

    for (genvar i = 0; i < NUM_CTX; i++) begin : g_entry
        logic sel;
        assign sel = set_en && (set_idx == CTX_W'(i));

        always_ff @(posedge clk) begin
            if (rst) begin
                valid_vec[i] <= 1'b0;
                tag_q[i]     <= '0;
            end else if (sel) begin
                valid_vec[i] <= 1'b1;
                tag_q[i]     <= probe_tag;
            end else if (kill_mask[i]) begin
                valid_vec[i] <= 1'b0;
            end
        end

        assign tag_hit[i] = valid_vec[i] && (tag_q[i] == probe_tag);
    end

endmodule

// File: rtl/resv_decide.sv
module resv_decide
    import resv_pkg::*;
#(
    parameter int NUM_CTX = 4,
    parameter int CTX_W   = 2
) (
    input  logic               req_valid,
    input  resv_cmd_e          cmd,
    input  logic [CTX_W-1:0]   req_ctx,
    input  logic [NUM_CTX-1:0] tag_hit,
    output logic               store_ok,
    output logic               sc_status,
    output logic               set_en,
    output logic [NUM_CTX-1:0] kill_mask,
    output logic [NUM_CTX-1:0] notify_mask
);

    cmd_class_t         cls;
    logic               own_hit;
    logic               proceed;
    logic [NUM_CTX-1:0] self_bit;

    always_comb begin
        cls      = classify(req_valid, cmd);
        self_bit = '0;
        own_hit  = 1'b0;
        for (int i = 0; i < NUM_CTX; i++) begin
            if (req_ctx == CTX_W'(i)) begin
                self_bit[i] = 1'b1;
                own_hit     = tag_hit[i];
            end
        end
        sc_status   = cls.cond_st && own_hit;
        proceed     = cls.plain_st || sc_status;
        store_ok    = proceed;
        set_en      = cls.reserve;
        kill_mask   = proceed ? tag_hit : '0;
        notify_mask = kill_mask & ~self_bit;
    end

endmodule

// File: rtl/resv_notify.sv
module resv_notify #(
    parameter int NUM_CTX = 4,
    parameter int CTX_W   = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_CTX-1:0] load_mask,
    output logic               clr_valid,
    output logic [CTX_W-1:0]   clr_ctx,
    output logic               busy
);

    logic [NUM_CTX-1:0] pending_q;
    logic [NUM_CTX-1:0] grant;

    always_comb begin
        grant   = '0;
        clr_ctx = '0;
        for (int i = NUM_CTX - 1; i >= 0; i--) begin
            if (pending_q[i]) begin
                grant   = '0;
                grant[i] = 1'b1;
                clr_ctx = CTX_W'(i);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) pending_q <= '0;
        else     pending_q <= (pending_q & ~grant) | load_mask;
    end

    assign clr_valid = |pending_q;
    assign busy      = |pending_q;

    p_ascending_r9: assert property (@(posedge clk) disable iff (rst)
        (clr_valid && $past(clr_valid) && ($past(load_mask) == '0))
            |-> (clr_ctx > $past(clr_ctx)));

    p_one_grant_r9: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

endmodule

// File: rtl/resv_monitor.sv
module resv_monitor
    import resv_pkg::*;
#(
    parameter int NUM_CTX   = 4,
    parameter int ADDR_W    = 32,
    parameter int GRAN_BYTES = 16,
    parameter int CTX_W     = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [1:0]        req_cmd,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [CTX_W-1:0]  req_ctx,
    output logic              store_ok,
    output logic              sc_status,
    output logic              clr_valid,
    output logic [CTX_W-1:0]  clr_ctx,
    output logic              busy
);

    localparam int GRAN_LSB = (GRAN_BYTES > 1) ? $clog2(GRAN_BYTES) : 0;
    localparam int TAG_W    = ADDR_W - GRAN_LSB;

    resv_cmd_e          cmd;
    logic [TAG_W-1:0]   tag;
    logic [NUM_CTX-1:0] tag_hit;
    logic [NUM_CTX-1:0] valid_vec;
    logic [NUM_CTX-1:0] kill_mask;
    logic [NUM_CTX-1:0] notify_mask;
    logic               set_en;

    assign cmd = resv_cmd_e'(req_cmd);
    assign tag = req_addr[ADDR_W-1:GRAN_LSB];

    resv_table #(.NUM_CTX(NUM_CTX), .TAG_W(TAG_W), .CTX_W(CTX_W)) u_table (
        .clk       (clk),
        .rst       (rst),
        .set_en    (set_en),
        .set_idx   (req_ctx),
        .probe_tag (tag),
        .kill_mask (kill_mask),
        .tag_hit   (tag_hit),
        .valid_vec (valid_vec)
    );

    resv_decide #(.NUM_CTX(NUM_CTX), .CTX_W(CTX_W)) u_decide (
        .req_valid   (req_valid),
        .cmd         (cmd),
        .req_ctx     (req_ctx),
        .tag_hit     (tag_hit),
        .store_ok    (store_ok),
        .sc_status   (sc_status),
        .set_en      (set_en),
        .kill_mask   (kill_mask),
        .notify_mask (notify_mask)
    );

    resv_notify #(.NUM_CTX(NUM_CTX), .CTX_W(CTX_W)) u_notify (
        .clk       (clk),
        .rst       (rst),
        .load_mask (notify_mask),
        .clr_valid (clr_valid),
        .clr_ctx   (clr_ctx),
        .busy      (busy)
    );

    p_plain_store_r5: assert property (@(posedge clk) disable iff (rst)
        (req_valid && cmd == CMD_STORE) |-> (store_ok && !sc_status));

    p_store_kills_granule_r6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && cmd == CMD_STORE_COND && $past(req_valid && store_ok)
            && ($past(tag) == tag)) |-> !sc_status);

    p_sc_consumes_r2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && cmd == CMD_STORE_COND && sc_status)
            |=> !valid_vec[$past(req_ctx)]);

    p_failed_sc_keeps_r7: assert property (@(posedge clk) disable iff (rst)
        $past(req_valid && cmd == CMD_STORE_COND && !sc_status)
            |-> (valid_vec == $past(valid_vec)));

endmodule

// File: tb/sim_resv_monitor.sv
module sim_resv_monitor;

    localparam int NC = 4;
    localparam int AW = 32;
    localparam int CW = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic [1:0]    req_cmd = 2'd0;
    logic [AW-1:0] req_addr = '0;
    logic [CW-1:0] req_ctx = '0;
    logic          store_ok, sc_status, clr_valid, busy;
    logic [CW-1:0] clr_ctx;

    int checks = 0;
    int errors = 0;
    logic got_ok, got_sc;

    always #5 clk = ~clk;

    resv_monitor #(.NUM_CTX(NC), .ADDR_W(AW), .GRAN_BYTES(16)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_cmd(req_cmd),
        .req_addr(req_addr), .req_ctx(req_ctx), .store_ok(store_ok),
        .sc_status(sc_status), .clr_valid(clr_valid), .clr_ctx(clr_ctx),
        .busy(busy)
    );

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One request: driven at negedge, outputs captured 1 ns later, strobe dropped after the edge.
    task automatic issue(input logic [1:0] c, input int ctx, input logic [AW-1:0] a);
        @(negedge clk);
        req_valid = 1'b1;
        req_cmd   = c;
        req_ctx   = CW'(ctx);
        req_addr  = a;
        #1;
        got_ok = store_ok;
        got_sc = sc_status;
        @(posedge clk);
        #1;
        req_valid = 1'b0;
    endtask

    task automatic sc_expect(input int ctx, input logic [AW-1:0] a, input logic exp, input string req);
        issue(2'd3, ctx, a);
        chk(got_sc == exp && got_ok == exp, req, int'(got_sc), int'(exp));
    endtask

    task automatic idle_expect(input string req);
        chk(!clr_valid && !busy, req, int'(clr_valid), 0);
    endtask

    task automatic t_reset;
        idle_expect("R1");
        sc_expect(0, 32'h0, 1'b0, "R1");
    endtask

    task automatic t_reserve_granule;
        issue(2'd1, 1, 32'h100);
        sc_expect(1, 32'h10C, 1'b1, "R2");
        sc_expect(1, 32'h100, 1'b0, "R6");
        idle_expect("R8");
    endtask

    task automatic t_overwrite;
        issue(2'd1, 2, 32'h200);
        issue(2'd1, 2, 32'h300);
        sc_expect(2, 32'h200, 1'b0, "R3");
        sc_expect(2, 32'h304, 1'b1, "R3");
    endtask

    task automatic t_fail_cases;
        issue(2'd1, 0, 32'h400);
        sc_expect(1, 32'h400, 1'b0, "R4");
        sc_expect(0, 32'h410, 1'b0, "R4");
        sc_expect(3, 32'h900, 1'b0, "R4");
        sc_expect(0, 32'h408, 1'b1, "R7");
    endtask

    task automatic t_plain_store_train;
        issue(2'd1, 3, 32'h500);
        issue(2'd1, 0, 32'h504);
        issue(2'd1, 1, 32'h50F);
        issue(2'd1, 2, 32'h600);
        issue(2'd2, 1, 32'h508);
        chk(got_ok == 1'b1 && got_sc == 1'b0, "R5", int'(got_ok), 1);
        chk(clr_valid && busy && clr_ctx == 2'd0, "R8", int'(clr_ctx), 0);
        @(posedge clk); #1;
        chk(clr_valid && busy && clr_ctx == 2'd3, "R9", int'(clr_ctx), 3);
        @(posedge clk); #1;
        chk(!clr_valid && !busy, "R9", int'(busy), 0);
        sc_expect(0, 32'h500, 1'b0, "R6");
        sc_expect(1, 32'h500, 1'b0, "R6");
        sc_expect(2, 32'h600, 1'b1, "R6");
    endtask

    task automatic t_sc_clears_others;
        issue(2'd1, 0, 32'h800);
        issue(2'd1, 2, 32'h800);
        issue(2'd1, 3, 32'h800);
        sc_expect(2, 32'h800, 1'b1, "R2");
        chk(clr_valid && clr_ctx == 2'd0, "R8", int'(clr_ctx), 0);
        @(posedge clk); #1;
        chk(clr_valid && clr_ctx == 2'd3, "R9", int'(clr_ctx), 3);
        @(posedge clk); #1;
        idle_expect("R8");
        sc_expect(3, 32'h800, 1'b0, "R6");
    endtask

    task automatic t_plain_load;
        issue(2'd1, 3, 32'h700);
        issue(2'd0, 3, 32'h700);
        chk(got_ok == 1'b0 && got_sc == 1'b0, "R10", int'(got_ok), 0);
        issue(2'd0, 0, 32'h704);
        idle_expect("R10");
        sc_expect(3, 32'h700, 1'b1, "R10");
    endtask

    task automatic t_store_unreserved;
        issue(2'd2, 2, 32'hA00);
        chk(got_ok == 1'b1 && got_sc == 1'b0, "R5", int'(got_ok), 1);
        idle_expect("R8");
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset;
        t_reserve_granule;
        t_overwrite;
        t_fail_cases;
        t_plain_store_train;
        t_sc_clears_others;
        t_plain_load;
        t_store_unreserved;
        repeat (2) @(posedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule